// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block is the machine-mode trap logic for resumable non-maskable interrupts in a small RISC-V style core. A vector of level-sensitive NMI request lines is sampled into a pending vector. While the NMI-enable flag is set and any pending bit is high, the block redirects the core to a fixed interrupt vector in machine mode. On that redirect it also records the interrupted PC, the privilege level and the cause. While the handler runs, NMI-enable is clear. In that state ordinary interrupts are masked, and any synchronous exception is forced to machine mode at a separate NMI exception vector, with delegation bypassed.

The block holds four CSRs: scratch, saved PC, cause and status. They are reached through a simple CSR port at addresses 0x350 to 0x353. The core reports each retired instruction, and from that the block recognises a dedicated return instruction. A legal return sends the core back to the saved PC at the saved privilege level and sets NMI-enable again. An illegal or misaligned return is flagged to the core's ordinary trap logic, which handles it. The pipeline, the ordinary trap CSRs and memory protection sit outside the block.

Top module: `nmi_trap_unit`

## Requirements
- R1: Each request line is copied into its own pending bit on every clock edge. An NMI entry can therefore occur in the cycle after a line is first seen high, provided no synchronous exception and no return instruction is presented in that cycle.
- R2: An NMI entry is taken when NMI-enable is 1 and the pending vector is nonzero. It raises a one-cycle redirect to IRQ_VEC with privilege 3 (machine; privilege codes are 0 user, 1 supervisor, 3 machine). At the clock edge that ends that cycle it also does all of the following:
  - clears NMI-enable;
  - stores the current PC in the saved-PC CSR (0x351);
  - stores the index of the lowest set pending bit in the cause CSR (0x352), with its top bit clear;
  - stores the current privilege in status bits 12:11 (0x353).
- R3: While NMI-enable is 0, irq_block is 1 and no further NMI entry is taken.
- R4: A synchronous exception presented while NMI-enable is 0 raises a redirect to EXC_VEC with privilege 3 in the same cycle, and asserts exc_nodeleg. The exception has priority over a return instruction and over an NMI entry in that cycle.
- R5: The CSR port reads and writes the scratch (0x350), saved-PC (0x351) and cause (0x352) CSRs at full width. A read returns the current value in the same cycle. A write takes effect at the clock edge. Addresses outside 0x350 to 0x353 read as zero.
- R6: A write to the status CSR (0x353) keeps only bits 12:11. Every other status bit reads as zero.
- R7: While feat_en is 0, any access to 0x350 to 0x353 asserts csr_illegal, reads zero and writes nothing. In that state no NMI entry or exception redirect occurs, and irq_block is 0.
- R8: The return instruction is the 32-bit word 0x70200073. Retiring it below privilege 3, or while feat_en is 0, asserts ret_illegal and changes no state.
- R9: With ALLOW_COMPRESSED=0, a return at privilege 3 while bits 1:0 of the saved PC are nonzero asserts ret_misaligned and raises no redirect.
- R10: A legal return raises a redirect to the saved PC, at the privilege held in status bits 12:11, and sets NMI-enable back to 1.
- R11: After reset, NMI-enable is 1 and all four CSRs read as zero.
- R12: A CSR write in the same cycle as an NMI entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | NMI feature enable |
| nmi_req | input | NLINES | Level-sensitive NMI request lines |
| cur_pc | input | XLEN | PC of the current instruction |
| cur_priv | input | 2 | Current privilege level |
| exc_valid | input | 1 | Synchronous exception raised this cycle |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_insn | input | 32 | Encoding of the retiring instruction |
| csr_valid | input | 1 | CSR access request |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, same cycle |
| csr_illegal | output | 1 | NMI CSR accessed while the feature is off |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_pc | output | XLEN | Redirect target PC |
| redir_priv | output | 2 | Privilege after the redirect |
| irq_block | output | 1 | Masks ordinary interrupts |
| exc_nodeleg | output | 1 | Exception goes to the NMI exception vector without delegation |
| ret_illegal | output | 1 | Return instruction is illegal |
| ret_misaligned | output | 1 | Return target is misaligned |

## Verification
The redirect, the CSR read data and all the flags are combinational, so each is due in the same cycle as the stimulus that causes it. CSR updates, NMI-enable changes and pending-bit updates appear one cycle later. A request line therefore produces an entry one cycle after it rises. The bench drives its inputs after the falling edge and compares every output one time unit later against a reference model. It advances that model at the next rising edge, so each check lands in the cycle where its result is due.

// File: rtl/nmi_trap_unit.sv
module nmi_trap_unit #(
  parameter int XLEN = 32,
  parameter int NLINES = 8,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h1000,
  parameter logic [XLEN-1:0] EXC_VEC = 'h1000,
  parameter bit ALLOW_COMPRESSED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic [NLINES-1:0] nmi_req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [1:0]        cur_priv,
  input  logic              exc_valid,
  input  logic              retire_valid,
  input  logic [31:0]       retire_insn,
  input  logic              csr_valid,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic [1:0]        redir_priv,
  output logic              irq_block,
  output logic              exc_nodeleg,
  output logic              ret_illegal,
  output logic              ret_misaligned
);

  localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [31:0] RET_WORD = 32'h7020_0073;
  localparam logic [1:0]  PRIV_M = 2'b11;
  localparam logic [11:0] A_SCRATCH = 12'h350;
  localparam logic [11:0] A_EPC = 12'h351;
  localparam logic [11:0] A_CAUSE = 12'h352;
  localparam logic [11:0] A_STATUS = 12'h353;
  localparam int MPP_LO = 11;

  logic [NLINES-1:0] pend_q;
  logic              en_q;
  logic [XLEN-1:0]   scratch_q, epc_q, cause_q;
  logic [1:0]        mpp_q;
  logic [IDXW-1:0]   low_idx;
  logic [XLEN-1:0]   status_view;

  always_comb begin
    low_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend_q[i]) low_idx = IDXW'(i);
  end

  assign status_view = XLEN'({mpp_q, {MPP_LO{1'b0}}});

  wire is_ret    = retire_valid && (retire_insn == RET_WORD);
  wire ret_seen  = is_ret && !exc_valid;
  wire ret_legal = feat_en && ret_seen && (cur_priv == PRIV_M);
  wire ret_bad   = ret_legal && !ALLOW_COMPRESSED && (epc_q[1:0] != 2'b00);
  wire ret_go    = ret_legal && !ret_bad;
  wire exc_nmi   = feat_en && exc_valid && !en_q;
  wire take_nmi  = feat_en && en_q && (|pend_q) && !exc_valid && !is_ret;
  wire csr_hit   = csr_valid && (csr_addr[11:2] == A_SCRATCH[11:2]);
  wire csr_wr    = csr_hit && csr_we && feat_en;

  assign csr_illegal    = csr_hit && !feat_en;
  assign ret_illegal    = ret_seen && !ret_legal;
  assign ret_misaligned = ret_bad;
  assign exc_nodeleg    = exc_nmi;
  assign irq_block      = feat_en && !en_q;
  assign redir_valid    = exc_nmi || ret_go || take_nmi;

  always_comb begin
    redir_pc   = '0;
    redir_priv = PRIV_M;
    if (exc_nmi) begin
      redir_pc = EXC_VEC;
    end else if (ret_go) begin
      redir_pc   = epc_q;
      redir_priv = mpp_q;
    end else if (take_nmi) begin
      redir_pc = IRQ_VEC;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_hit && feat_en) begin
      case (csr_addr)
        A_SCRATCH: csr_rdata = scratch_q;
        A_EPC:     csr_rdata = epc_q;
        A_CAUSE:   csr_rdata = cause_q;
        A_STATUS:  csr_rdata = status_view;
        default:   csr_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      en_q      <= 1'b1;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      mpp_q     <= '0;
    end else begin
      pend_q <= nmi_req;
      if (take_nmi) begin
        en_q    <= 1'b0;
        epc_q   <= cur_pc;
        cause_q <= XLEN'(low_idx);
        mpp_q   <= cur_priv;
      end else begin
        if (ret_go) en_q <= 1'b1;
        if (csr_wr) begin
          case (csr_addr)
            A_SCRATCH: scratch_q <= csr_wdata;
            A_EPC:     epc_q     <= csr_wdata;
            A_CAUSE:   cause_q   <= csr_wdata;
            A_STATUS:  mpp_q     <= csr_wdata[MPP_LO+1:MPP_LO];
            default:   ;
          endcase
        end
      end
    end
  end

  a_r2_entry_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> !en_q);
  a_r2_entry_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> epc_q == $past(cur_pc));
  a_r3_entry_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> !take_nmi);
  a_r4_exc_to_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_nmi |-> redir_valid && redir_pc == EXC_VEC && redir_priv == PRIV_M);
  a_r8_illegal_ret_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ret_illegal && !take_nmi |=> en_q == $past(en_q));
  a_r10_return_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> en_q);

endmodule

// File: tb/test_nmi_trap_unit.sv
module test_nmi_trap_unit;
  localparam int CLK_P = 10;
  localparam int XLEN = 32;
  localparam int NL = 8;
  localparam logic [31:0] VEC = 32'h1000;
  localparam logic [31:0] RET = 32'h7020_0073;

  logic clk = 1'b0, rst_n = 1'b0, feat_en = 1'b1;
  logic [NL-1:0] nmi_req = '0;
  logic [XLEN-1:0] cur_pc = '0, csr_wdata = '0;
  logic [1:0] cur_priv = 2'b11;
  logic exc_valid = 1'b0, retire_valid = 1'b0, csr_valid = 1'b0, csr_we = 1'b0;
  logic [31:0] retire_insn = '0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_rdata, redir_pc;
  logic csr_illegal, redir_valid, irq_block, exc_nodeleg, ret_illegal, ret_misaligned;
  logic [1:0] redir_priv;

  nmi_trap_unit i_nmi_trap_unit (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic m_en; logic [NL-1:0] m_pend; logic [31:0] m_scr, m_epc, m_cause; logic [1:0] m_mpp;
  logic e_rv, e_ill, e_mis, e_exc, e_take, e_go, e_cill, e_blk; logic [31:0] e_pc, e_rd; logic [1:0] e_pr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    logic isr, seen, legal, hit;
    isr = retire_valid && retire_insn == RET;
    seen = isr && !exc_valid;
    legal = feat_en && seen && cur_priv == 2'b11;
    e_ill = seen && !legal;
    e_mis = legal && m_epc[1:0] != 0;
    e_go = legal && !e_mis;
    e_exc = feat_en && exc_valid && !m_en;
    e_take = feat_en && m_en && m_pend != 0 && !exc_valid && !isr;
    e_rv = e_exc || e_go || e_take;
    e_pc = e_exc ? VEC : e_go ? m_epc : VEC;
    e_pr = (e_go && !e_exc) ? m_mpp : 2'b11;
    e_blk = feat_en && !m_en;
    hit = csr_valid && csr_addr[11:2] == 10'h0D4;
    e_cill = hit && !feat_en;
    e_rd = 0;
    if (hit && feat_en)
      case (csr_addr[1:0])
        2'd0: e_rd = m_scr;
        2'd1: e_rd = m_epc;
        2'd2: e_rd = m_cause;
        default: e_rd = {19'd0, m_mpp, 11'd0};
      endcase
  endtask

  task automatic model_update();
    if (e_take) begin
      m_en = 0; m_epc = cur_pc; m_mpp = cur_priv;
      m_cause = 0;
      for (int i = NL - 1; i >= 0; i--) if (m_pend[i]) m_cause = i;
    end else begin
      if (e_go) m_en = 1;
      if (csr_valid && csr_we && feat_en && csr_addr[11:2] == 10'h0D4)
        case (csr_addr[1:0])
          2'd0: m_scr = csr_wdata;
          2'd1: m_epc = csr_wdata;
          2'd2: m_cause = csr_wdata;
          default: m_mpp = csr_wdata[12:11];
        endcase
    end
    m_pend = nmi_req;
  endtask

  task automatic step();
    #1;
    model_eval();
    if (e_exc) chk("R4 redir_valid", redir_valid, 1);
    else if (e_go) chk("R10 redir_valid", redir_valid, 1);
    else if (e_take) chk("R2 redir_valid", redir_valid, 1);
    else if (m_pend != 0 && !m_en) chk("R3 redir_valid", redir_valid, 0);
    else chk("R1 redir_valid", redir_valid, 0);
    if (e_rv) begin
      chk(e_exc ? "R4 redir_pc" : e_go ? "R10 redir_pc" : "R2 redir_pc", redir_pc, e_pc);
      chk(e_exc ? "R4 redir_priv" : e_go ? "R10 redir_priv" : "R2 redir_priv", 32'(redir_priv), 32'(e_pr));
    end
    chk("R3 irq_block", 32'(irq_block), 32'(e_blk));
    chk("R4 exc_nodeleg", 32'(exc_nodeleg), 32'(e_exc));
    chk("R7 csr_illegal", 32'(csr_illegal), 32'(e_cill));
    chk(csr_addr == 12'h353 ? "R6 csr_rdata" : "R5 csr_rdata", csr_rdata, e_rd);
    chk("R8 ret_illegal", 32'(ret_illegal), 32'(e_ill));
    chk("R9 ret_misaligned", 32'(ret_misaligned), 32'(e_mis));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    exc_valid = 0; retire_valid = 0; csr_valid = 0; csr_we = 0;
  endtask

  task automatic csr_rd(logic [11:0] a);
    idle(); csr_valid = 1; csr_addr = a; step(); idle();
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    idle(); csr_valid = 1; csr_we = 1; csr_addr = a; csr_wdata = d; step(); idle();
  endtask

  task automatic retire_ret(logic [1:0] p);
    idle(); cur_priv = p; retire_valid = 1; retire_insn = RET; step(); idle();
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20210309));
    m_en = 1; m_pend = 0; m_scr = 0; m_epc = 0; m_cause = 0; m_mpp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    #1;
    chk("R11 irq_block", 32'(irq_block), 0);
    chk("R11 redir_valid", 32'(redir_valid), 0);
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      csr_rd(12'h350 + 12'(a));
      #1 chk("R11 csr zero", m_scr | m_epc | m_cause | 32'(m_mpp), 0);
    end
    // R5/R6 CSR access and status mask
    csr_wr(12'h350, 32'hDEAD_BEEF); csr_rd(12'h350);
    csr_wr(12'h353, 32'hFFFF_FFFF); csr_rd(12'h353);
    csr_wr(12'h351, 32'h0000_2000); csr_rd(12'h340);
    // R1/R2 entry from line 5 and line 2, lowest wins; R12 write discard
    cur_pc = 32'h0000_4444; cur_priv = 2'b01; nmi_req = 8'b0010_0100;
    step();
    csr_valid = 1; csr_we = 1; csr_addr = 12'h350; csr_wdata = 32'h1111_1111;
    step(); idle();
    csr_rd(12'h350);
    chk("R12 scratch kept", m_scr, 32'hDEAD_BEEF);
    csr_rd(12'h352); csr_rd(12'h351); csr_rd(12'h353);
    // R3 blocked while in handler
    step(); step();
    // R4 exception inside handler
    exc_valid = 1; step(); idle();
    // R8 return below machine
    retire_ret(2'b00);
    // R9 misaligned return
    nmi_req = 0;
    csr_wr(12'h351, 32'h0000_3002);
    retire_ret(2'b11);
    // R10 good return
    csr_wr(12'h351, 32'h0000_3004);
    retire_ret(2'b11);
    chk("R10 enable rearmed", 32'(m_en), 1);
    step();
    // R7 feature disabled
    feat_en = 0; nmi_req = 8'h80;
    csr_wr(12'h350, 32'h5555_5555); csr_rd(12'h350);
    retire_ret(2'b11);
    step(); step();
    feat_en = 1; nmi_req = 0; step(); step();
    retire_ret(2'b11);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 0) nmi_req = (r[3] ? 8'($urandom) & 8'($urandom) : 8'h00);
      cur_pc = $urandom;
      case ($urandom % 3) 0: cur_priv = 2'b00; 1: cur_priv = 2'b01; default: cur_priv = 2'b11; endcase
      exc_valid = ($urandom % 12) == 0;
      retire_valid = ($urandom % 3) == 0;
      retire_insn = ($urandom % 3 == 0) ? RET : $urandom;
      csr_valid = ($urandom % 3) == 0;
      csr_we = $urandom % 2;
      csr_addr = ($urandom % 5 == 0) ? 12'h340 + 12'($urandom % 16) : 12'h350 + 12'($urandom % 4);
      csr_wdata = $urandom;
      if ($urandom % 2 == 0) csr_wdata[1:0] = 2'b00;
      feat_en = (n < 2000) ? 1'b1 : (($urandom % 20) != 0);
      step();
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule